// File: doc/BRIEF.md
# Charger Power-Path Protection Sequencer

This block is the control state machine of a safety switch placed in series with a battery charger's supply. It takes already-qualified fault flags and decides when the pass switch may conduct. The flags cover input overvoltage, battery overvoltage, overcurrent, a hot-die flag with a separate cool-down flag, and a permanent latch-off request. It also takes a power-on-reset flag and a disable pin. It drives a gate command, a select that chooses fast or slow turn-off, a soft-start ramp code and an active-low warning.

Every turn-on follows the same path. The controller waits through a settling delay, then ramps the switch on, and only then holds it fully on. Any blocking condition sends it back to the off state, and the whole path starts again from the beginning. Because of this, an input overvoltage that comes back before the delay expires never lets the switch conduct. All delays are counted in clock cycles and set by parameters. Each asynchronous input passes through a synchronizer of `SYNC_STAGES` flops, so any input change reaches the registered outputs three clock edges later.

Top module: `chg_path_seq`

## Requirements
- R1: While `por_req` is high the gate is off, and `warn_n` and `fast_off` are inactive. A synchronous `rst` sets the same state, with `ramp_code` at 0.
- R2: After the last blocking condition clears, `gate_on` rises exactly `SETTLE_CYC + 3` cycles after the input change.
- R3: When the gate turns on, `ramp_code` starts at 0 and rises by one every `STEP_CYC` cycles until it reaches all ones. It then holds that value while the switch stays on.
- R4: `vin_ov` turns the gate off 3 cycles after it rises, with no blanking. `fast_off` goes high in the same cycle.
- R5: After `vin_ov` clears, turn-on needs the full settling delay again. If `vin_ov` returns within `SETTLE_CYC` cycles of clearing, `gate_on` never rises.
- R6: `batt_ov` or `over_cur` turns the gate off with `fast_off` low and `warn_n` low. Normal start-up resumes once the flag clears.
- R7: `temp_hot` latches an off state with `warn_n` low. The latch holds after `temp_hot` falls and releases only when `temp_cool` is high while `temp_hot` is low.
- R8: A pulse on `latch_off` holds the gate off with `warn_n` low until `disable_req` goes high or `por_req` is asserted. The next start-up then runs the full settling delay and ramp.
- R9: `disable_req` high turns the gate off with `fast_off` low and `warn_n` high.
- R10: Priority is `por_req`, then `disable_req`, then `vin_ov`, then the other faults. A higher input masks `fast_off` and `warn_n` for a lower one, and `vin_ov` keeps `fast_off` high even while another fault is also active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_req | input | 1 | Power-on-reset flag, asynchronous |
| disable_req | input | 1 | Shutdown request, high disables |
| vin_ov | input | 1 | Input overvoltage flag |
| batt_ov | input | 1 | Qualified battery overvoltage flag |
| over_cur | input | 1 | Qualified overcurrent flag |
| temp_hot | input | 1 | Die above the upper temperature threshold |
| temp_cool | input | 1 | Die below the lower temperature threshold |
| latch_off | input | 1 | Permanent latch-off request from the fault counter |
| gate_on | output | 1 | Pass-switch gate command |
| fast_off | output | 1 | High selects fast turn-off |
| ramp_code | output | RAMP_W | Soft-start drive strength |
| warn_n | output | 1 | Active-low protection warning |

## Verification
The bench builds the block with `SETTLE_CYC` = 20, `RAMP_W` = 3 and `STEP_CYC` = 3. A whole start-up therefore takes about 45 cycles, and the bench can count every cycle of the settling delay and every ramp step against arithmetic expectations. It sweeps the re-assertion gap of the input overvoltage across every value from 1 to `SETTLE_CYC + 3`, which covers both sides of the boundary where the switch first gets a chance to conduct. It also measures the start-up latency after each kind of fault release and checks the priority masking on `fast_off` and `warn_n`.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RAMP   = 2'd2,
    ST_ON     = 2'd3
  } cps_state_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(LIMIT-1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run) cnt <= done ? '0 : cnt + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT-1));
endmodule

// File: rtl/cps_ramp.sv
module cps_ramp #(
  parameter int unsigned CODE_W   = 6,
  parameter int unsigned STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  output logic [CODE_W-1:0] code,
  output logic              full
);
  localparam int unsigned MAXC = (1 << CODE_W) - 1;
  localparam int unsigned SW   = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [SW-1:0] step;
  logic          tick;

  assign tick = run && (step == SW'(STEP_CYC-1));
  assign full = tick && (code == CODE_W'(MAXC-1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      step <= '0;
      code <= '0;
    end else if (run) begin
      step <= tick ? '0 : step + 1'b1;
      if (tick && code != CODE_W'(MAXC)) code <= code + 1'b1;
    end
  end

  // R3
  ramp_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (code >= $past(code)) && (code - $past(code) <= 1));
endmodule

// File: rtl/chg_path_seq.sv
module chg_path_seq
  import cps_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 1000000,
  parameter int unsigned RAMP_W      = 6,
  parameter int unsigned STEP_CYC    = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_req,
  input  logic              disable_req,
  input  logic              vin_ov,
  input  logic              batt_ov,
  input  logic              over_cur,
  input  logic              temp_hot,
  input  logic              temp_cool,
  input  logic              latch_off,
  output logic              gate_on,
  output logic              fast_off,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              warn_n
);
  localparam int unsigned NIN = 8;

  logic [NIN-1:0] raw_in, syn;
  logic por_s, en_s, ov_s, bovp_s, ocp_s, hot_s, cool_s, lock_s;

  assign raw_in = {latch_off, temp_cool, temp_hot, over_cur,
                   batt_ov, vin_ov, disable_req, por_req};

  cps_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign {lock_s, cool_s, hot_s, ocp_s, bovp_s, ov_s, en_s, por_s} = syn;

  cps_state_e state_q, state_d;
  logic hot_q, hot_d, lock_q, lock_d;
  logic fault_any, blocked, settle_done, ramp_full;

  always_comb begin
    if (por_s)       hot_d = 1'b0;
    else if (hot_s)  hot_d = 1'b1;
    else if (cool_s) hot_d = 1'b0;
    else             hot_d = hot_q;

    if (por_s || en_s) lock_d = 1'b0;
    else if (lock_s)   lock_d = 1'b1;
    else               lock_d = lock_q;

    fault_any = ov_s | bovp_s | ocp_s | hot_d | lock_d;
    blocked   = por_s | en_s | fault_any;

    state_d = state_q;
    if (blocked) state_d = ST_OFF;
    else begin
      case (state_q)
        ST_OFF:    state_d = ST_SETTLE;
        ST_SETTLE: if (settle_done) state_d = ST_RAMP;
        ST_RAMP:   if (ramp_full) state_d = ST_ON;
        default:   state_d = ST_ON;
      endcase
    end
  end

  cps_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst),
    .clr(blocked || state_q != ST_SETTLE),
    .run(state_q == ST_SETTLE),
    .done(settle_done)
  );

  cps_ramp #(.CODE_W(RAMP_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk(clk), .rst(rst),
    .clr(blocked || !(state_q == ST_RAMP || state_q == ST_ON)),
    .run(state_q == ST_RAMP),
    .code(ramp_code),
    .full(ramp_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      hot_q    <= 1'b0;
      lock_q   <= 1'b0;
      gate_on  <= 1'b0;
      fast_off <= 1'b0;
      warn_n   <= 1'b1;
    end else begin
      state_q  <= state_d;
      hot_q    <= hot_d;
      lock_q   <= lock_d;
      gate_on  <= (state_d == ST_RAMP) || (state_d == ST_ON);
      fast_off <= !por_s && !en_s && ov_s;
      warn_n   <= !(!por_s && !en_s && fault_any);
    end
  end

  // R1
  por_off_chk: assert property (@(posedge clk) disable iff (rst)
    por_s |=> !gate_on && warn_n && !fast_off);

  // R4
  ov_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_s && !por_s && !en_s) |=> !gate_on && fast_off);

  // R3
  ramp_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> ramp_code == '0);

  // R6
  slow_off_chk: assert property (@(posedge clk) disable iff (rst)
    ((bovp_s || ocp_s) && !ov_s && !por_s && !en_s) |=> !gate_on && !fast_off && !warn_n);

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    (en_s && !por_s) |=> !gate_on && warn_n && !fast_off);
endmodule

// File: tb/chg_path_seq_bench.sv
module chg_path_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SC   = 20;
  localparam int RW   = 3;
  localparam int STEP = 3;
  localparam int MAXC = (1 << RW) - 1;
  localparam int LAT  = SC + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_req = 1'b1, disable_req = 1'b0, vin_ov = 1'b0, batt_ov = 1'b0;
  logic over_cur = 1'b0, temp_hot = 1'b0, temp_cool = 1'b0, latch_off = 1'b0;
  logic gate_on, fast_off, warn_n;
  logic [RW-1:0] ramp_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_path_seq #(.SETTLE_CYC(SC), .RAMP_W(RW), .STEP_CYC(STEP), .SYNC_STAGES(2)) u_chg_path_seq (
    .clk(clk), .rst(rst), .por_req(por_req), .disable_req(disable_req),
    .vin_ov(vin_ov), .batt_ov(batt_ov), .over_cur(over_cur),
    .temp_hot(temp_hot), .temp_cool(temp_cool), .latch_off(latch_off),
    .gate_on(gate_on), .fast_off(fast_off), .ramp_code(ramp_code), .warn_n(warn_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_on(output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (!gate_on && n < 4*SC + 20);
  endtask

  task automatic outs(input string tag, input int g, input int f, input int w);
    chk({tag, " gate"}, int'(gate_on), g);
    chk({tag, " fast_off"}, int'(fast_off), f);
    chk({tag, " warn_n"}, int'(warn_n), w);
  endtask

  initial begin
    int n;
    int seen;
    step(4);
    // R1 reset state
    outs("R1 reset", 0, 0, 1);
    chk("R1 reset ramp", int'(ramp_code), 0);
    rst = 1'b0;
    step(SC + 10);
    outs("R1 por held", 0, 0, 1);

    // R2 start-up latency
    por_req = 1'b0;
    wait_on(n);
    chk("R2 startup latency", n, LAT);

    // R3 ramp profile
    for (int j = 0; j <= MAXC*STEP + 2; j++) begin
      chk("R3 ramp code", int'(ramp_code), (j / STEP > MAXC) ? MAXC : j / STEP);
      chk("R3 gate held", int'(gate_on), 1);
      step(1);
    end

    // R4 fast off
    vin_ov = 1'b1;
    step(2);
    chk("R4 still on before latency", int'(gate_on), 1);
    step(1);
    outs("R4 ov off", 0, 1, 0);
    chk("R4 ramp cleared", int'(ramp_code), 0);
    step(5);

    // R5 gap sweep
    for (int d = 1; d <= SC + 3; d++) begin
      vin_ov = 1'b0;
      seen = 0;
      for (int i = 0; i < d; i++) begin step(1); seen |= int'(gate_on); end
      vin_ov = 1'b1;
      for (int i = 0; i < SC + 6; i++) begin step(1); seen |= int'(gate_on); end
      chk($sformatf("R5 gap %0d turn-on seen", d), seen, (d > SC) ? 1 : 0);
      chk("R5 off after return", int'(gate_on), 0);
    end
    vin_ov = 1'b0;
    wait_on(n);
    chk("R5 restart latency", n, LAT);
    step(MAXC*STEP + 2);

    // R6 slow off
    batt_ov = 1'b1;
    step(3);
    outs("R6 batt ov", 0, 0, 0);
    batt_ov = 1'b0;
    wait_on(n);
    chk("R6 batt release latency", n, LAT);
    over_cur = 1'b1;
    step(3);
    outs("R6 over current", 0, 0, 0);
    over_cur = 1'b0;
    wait_on(n);
    chk("R6 ocp release latency", n, LAT);

    // R9 disable
    disable_req = 1'b1;
    step(3);
    outs("R9 disabled", 0, 0, 1);
    disable_req = 1'b0;
    wait_on(n);
    chk("R9 enable latency", n, LAT);

    // R7 thermal latch
    temp_hot = 1'b1;
    step(3);
    outs("R7 hot", 0, 0, 0);
    temp_hot = 1'b0;
    step(SC + 10);
    outs("R7 held until cool", 0, 0, 0);
    temp_cool = 1'b1;
    wait_on(n);
    chk("R7 cool release latency", n, LAT);
    temp_cool = 1'b0;

    // R8 latch-off
    latch_off = 1'b1;
    step(1);
    latch_off = 1'b0;
    step(3);
    outs("R8 latched", 0, 0, 0);
    step(SC + 10);
    outs("R8 still latched", 0, 0, 0);
    disable_req = 1'b1;
    step(4);
    outs("R8 cleared by disable", 0, 0, 1);
    disable_req = 1'b0;
    wait_on(n);
    chk("R8 restart latency", n, LAT);

    // R10 priority
    disable_req = 1'b1; vin_ov = 1'b1;
    step(3);
    outs("R10 disable over ov", 0, 0, 1);
    disable_req = 1'b0;
    step(3);
    outs("R10 ov alone", 0, 1, 0);
    batt_ov = 1'b1;
    step(3);
    outs("R10 ov with batt", 0, 1, 0);
    vin_ov = 1'b0;
    step(3);
    outs("R10 batt alone", 0, 0, 0);
    batt_ov = 1'b0;
    wait_on(n);
    chk("R10 release latency", n, LAT);
    por_req = 1'b1; vin_ov = 1'b1;
    step(3);
    outs("R10 por over ov", 0, 0, 1);
    por_req = 1'b0; vin_ov = 1'b0;
    wait_on(n);
    chk("R1 por release latency", n, LAT);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule